// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of up to 32 general-purpose lines behind a small memory-mapped port with 32-bit words. Every line is a general input, a general output, or an interrupt source. Each interrupt source has its own settings for polarity, edge or level sensing, and detection on both edges. Pin inputs pass through a two-flop synchroniser. Edge detection works on the synchronised level. Edge events are latched into a status word. Level-sensed lines show their qualified level in the same word without latching.

Software sets a mask word to pick which pending lines drive the single registered interrupt output. Writing the mask word can only clear enable bits. A separate unmask word can only set them, so one line can be changed without a read-modify-write. Latched edge status is cleared by writing ones to a clear word. Reads are combinational from the address, and writes take effect at the clock edge that samples `bus_valid` and `bus_write` high. One register select value (an enumerated type of word offsets) steers all accesses.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `pin_oe` is 0. Every line is then a general input with its interrupt disabled.
- R2: Word offsets are 0x00 mode (1 = interrupt input), 0x04 direction (1 = output), 0x08 output data, 0x20 polarity, 0x24 edge select (1 = edge), 0x28 filter enable and 0x4C both-edge select. Each reads back what was last written, and bits at or above NUM_LINES read 0. The filter-enable word is storage only and changes no behaviour.
- R3: `pin_out` equals the output-data word. A `pin_oe` bit is 1 only when its mode bit is 0 and its direction bit is 1.
- R4: Offset 0x0C returns the output-data bit for a general output line. For every other line it returns the pin level, which becomes visible two clock edges after it is applied.
- R5: The status word is at 0x10. A level-sensed interrupt line (mode 1, edge 0) shows its status as pin XOR polarity: a polarity of 0 is active high and 1 is active low. This status follows the pin and is not latched.
- R6: An edge-sensed line with both-edge 0 latches its status bit on a rising synchronised transition when polarity is 0, and on a falling one when polarity is 1.
- R7: An edge-sensed line with both-edge 1 latches its status on any transition, whatever its polarity bit holds.
- R8: Writing 1 to a bit at offset 0x14 clears that line's latched edge status. Bits written 0 leave it unchanged. An edge event in the same cycle takes priority over the clear.
- R9: The mask word is read at 0x18. A write there clears each enable bit written 0 and keeps each bit written 1. A write at 0x1C sets each bit written 1 and leaves the others. Offsets 0x14 and 0x1C read 0.
- R10: `irq` is the OR over all lines of status AND mask, registered once. It is 0 while every pending line is masked.
- R11: A line with mode 0 always has status 0. A latched edge status is dropped when its line leaves edge-interrupt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NUM_LINES | Pin levels from the pads |
| pin_out | output | NUM_LINES | Output data to the pads |
| pin_oe | output | NUM_LINES | Output enable to the pads |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The bench builds the bank with NUM_LINES = 8. With that size, each line's status can be checked as a full byte. The bench steps through all eight combinations of polarity, edge select and both-edge select, applying a computed pin sequence to every line at once. Each step is compared with an arithmetic model of the latched and level status, with periodic partial clears and with the IRQ. The narrow width also exposes the zero upper bits of every word, the exact two-edge synchroniser delay, and the mask and unmask arithmetic on patterned values.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODE   = 7'h00,
        SEL_DIR    = 7'h04,
        SEL_DOUT   = 7'h08,
        SEL_DIN    = 7'h0C,
        SEL_STAT   = 7'h10,
        SEL_CLR    = 7'h14,
        SEL_MASK   = 7'h18,
        SEL_UNMASK = 7'h1C,
        SEL_POL    = 7'h20,
        SEL_EDGE   = 7'h24,
        SEL_FILT   = 7'h28,
        SEL_BOTH   = 7'h4C
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level,
    input  logic [NUM_LINES-1:0] mode,
    input  logic [NUM_LINES-1:0] edge_sel,
    input  logic [NUM_LINES-1:0] pol,
    input  logic [NUM_LINES-1:0] both,
    input  logic [NUM_LINES-1:0] clr_bits,
    output logic [NUM_LINES-1:0] status
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] latch_q;
    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] edge_mode;
    logic [NUM_LINES-1:0] level_hit;

    assign edge_mode = mode & edge_sel;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic rise;
        logic fall;
        assign rise = ~prev_q[i] & level[i];
        assign fall = prev_q[i] & ~level[i];
        always_comb begin
            if (!edge_mode[i])     evt[i] = 1'b0;
            else if (both[i])      evt[i] = rise | fall;
            else if (pol[i])       evt[i] = fall;
            else                   evt[i] = rise;
        end
        assign level_hit[i] = mode[i] & ~edge_sel[i] & (level[i] ^ pol[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= level;
            latch_q <= (latch_q & ~clr_bits & edge_mode) | evt;
        end
    end

    assign status = (latch_q & edge_mode) | level_hit;

    // R6: a latched bit only appears after a detected event
    assert_edge_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q & ~$past(latch_q) & ~$past(evt)) == '0));

    // R8: a cleared bit without a coincident event is gone next cycle
    assert_clear_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_bits & ~evt) & latch_q) == '0));
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] din_sync,
    input  logic [NUM_LINES-1:0] status,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] dout_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] edge_q,
    output logic [NUM_LINES-1:0] both_q,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] clr_bits
);
    logic [NUM_LINES-1:0] filt_q;
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] drv_out;
    logic [NUM_LINES-1:0] rsel;
    logic                 wr;
    reg_sel_e             sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr      = bus_valid & bus_write;
    assign wbits   = bus_wdata[NUM_LINES-1:0];
    assign drv_out = ~mode_q & dir_q;
    assign clr_bits = (wr && sel == SEL_CLR) ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            both_q <= '0;
            filt_q <= '0;
            mask_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_MODE:   mode_q <= wbits;
                SEL_DIR:    dir_q  <= wbits;
                SEL_DOUT:   dout_q <= wbits;
                SEL_POL:    pol_q  <= wbits;
                SEL_EDGE:   edge_q <= wbits;
                SEL_BOTH:   both_q <= wbits;
                SEL_FILT:   filt_q <= wbits;
                SEL_MASK:   mask_q <= mask_q & wbits;
                SEL_UNMASK: mask_q <= mask_q | wbits;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: rsel = mode_q;
            SEL_DIR:  rsel = dir_q;
            SEL_DOUT: rsel = dout_q;
            SEL_DIN:  rsel = (dout_q & drv_out) | (din_sync & ~drv_out);
            SEL_STAT: rsel = status;
            SEL_MASK: rsel = mask_q;
            SEL_POL:  rsel = pol_q;
            SEL_EDGE: rsel = edge_q;
            SEL_FILT: rsel = filt_q;
            SEL_BOTH: rsel = both_q;
            default:  rsel = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[NUM_LINES-1:0] = rsel;
    end

    // R9: a write to the mask word never enables a line
    assert_mask_write_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_MASK) |=> ((mask_q & ~$past(mask_q)) == '0));

    // R9: a write to the unmask word never disables a line
    assert_unmask_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_UNMASK) |=> ((~mask_q & $past(mask_q)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [6:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq
);
    logic [NUM_LINES-1:0] din_sync;
    logic [NUM_LINES-1:0] status;
    logic [NUM_LINES-1:0] mode_q, dir_q, dout_q, pol_q, edge_q, both_q, mask_q;
    logic [NUM_LINES-1:0] clr_bits;
    logic                 irq_q;

    gpio_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(din_sync)
    );

    gpio_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din_sync(din_sync), .status(status),
        .mode_q(mode_q), .dir_q(dir_q), .dout_q(dout_q), .pol_q(pol_q),
        .edge_q(edge_q), .both_q(both_q), .mask_q(mask_q), .clr_bits(clr_bits)
    );

    gpio_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .level(din_sync),
        .mode(mode_q), .edge_sel(edge_q), .pol(pol_q), .both(both_q),
        .clr_bits(clr_bits), .status(status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & mask_q);
    end

    assign irq     = irq_q;
    assign pin_out = dout_q;
    assign pin_oe  = ~mode_q & dir_q;

    // R10: irq only follows an enabled pending line
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(status & mask_q)));

    // R3: an interrupt-mode line never drives its pad
    assert_oe_io_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & mode_q) == '0));

    // R11: general I/O lines never report status
    assert_io_no_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~mode_q) == '0));
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [6:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        logic [6:0] rw_addr [7];
        logic [7:0] pins, latch, st_exp, ev, cl;
        rw_addr = '{7'h00, 7'h04, 7'h08, 7'h20, 7'h24, 7'h28, 7'h4C};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 7; k++) begin
            rd(rw_addr[k], r); chk("R1 reg", r, 32'h0);
        end
        rd(7'h10, r); chk("R1 status", r, 32'h0);
        rd(7'h18, r); chk("R1 mask", r, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 oe", {24'h0, pin_oe}, 32'h0);

        // R2: readback with upper bits zero
        for (int k = 0; k < 7; k++) begin
            wr(rw_addr[k], 32'hABCD_0000 | (32'h13 * (k + 1)));
            rd(rw_addr[k], r);
            chk("R2 readback", r, (32'h13 * (k + 1)) & 32'hFF);
        end
        for (int k = 0; k < 7; k++) wr(rw_addr[k], 32'h0);
        wr(7'h14, 32'hFF);

        // R3 / R4: output drive and input read
        wr(7'h00, 32'h0F); wr(7'h04, 32'h3C); wr(7'h08, 32'h55);
        @(negedge clk);
        chk("R3 oe", {24'h0, pin_oe}, 32'h30);
        chk("R3 out", {24'h0, pin_out}, 32'h55);
        pin_in = 8'hCA;
        rd(7'h0C, r); chk("R4 sync delay old", r, (32'h55 & 32'h30));
        rd(7'h0C, r); chk("R4 sync delay new", r, (32'h55 & 32'h30) | (32'hCA & 32'hCF));
        wr(7'h00, 32'h0); wr(7'h04, 32'h0); wr(7'h08, 32'h0);
        chk("R3 oe off", {24'h0, pin_oe}, 32'h0);

        // R11: general I/O lines report no status
        wr(7'h24, 32'hFF); wr(7'h4C, 32'hFF);
        pin_in = 8'h35; settle();
        pin_in = 8'h00; settle();
        rd(7'h10, r); chk("R11 io status", r, 32'h0);
        wr(7'h24, 32'h0); wr(7'h4C, 32'h0);

        // R5..R8, R10: sweep of all sense configurations
        wr(7'h1C, 32'hFF);
        pins = pin_in;
        for (int cfg = 0; cfg < 8; cfg++) begin
            bit p, e, b;
            p = cfg[0]; e = cfg[1]; b = cfg[2];
            wr(7'h20, p ? 32'hFF : 32'h0);
            wr(7'h24, e ? 32'hFF : 32'h0);
            wr(7'h4C, b ? 32'hFF : 32'h0);
            wr(7'h28, cfg[0] ? 32'hFF : 32'h0);
            wr(7'h00, 32'hFF);
            wr(7'h14, 32'hFF);
            latch = '0;
            for (int step = 0; step < 12; step++) begin
                logic [7:0] nxt;
                nxt = 8'((step * 37 + cfg * 11) ^ (step << 2));
                if (b)      ev = pins ^ nxt;
                else if (p) ev = pins & ~nxt;
                else        ev = ~pins & nxt;
                if (e) latch = latch | ev;
                pins = nxt;
                @(negedge clk); pin_in = nxt;
                settle();
                st_exp = e ? latch : (pins ^ (p ? 8'hFF : 8'h00));
                rd(7'h10, r);
                chk(e ? (b ? "R7 both-edge status" : "R6 edge status") : "R5 level status",
                    r, {24'h0, st_exp});
                chk("R10 irq", {31'h0, irq}, {31'h0, |st_exp});
                if (step % 3 == 2) begin
                    cl = 8'(step * 29 + cfg);
                    wr(7'h14, {24'h0, cl});
                    if (e) latch = latch & ~cl;
                    rd(7'h10, r);
                    st_exp = e ? latch : (pins ^ (p ? 8'hFF : 8'h00));
                    chk("R8 clear", r, {24'h0, st_exp});
                end
            end
        end

        // R11: latched status dropped on leaving edge mode
        wr(7'h20, 32'h0); wr(7'h4C, 32'h0); wr(7'h24, 32'hFF);
        wr(7'h14, 32'hFF);
        @(negedge clk); pin_in = 8'h00; settle();
        @(negedge clk); pin_in = 8'h81; settle();
        rd(7'h10, r); chk("R11 latched before", r, 32'h81);
        wr(7'h00, 32'h00); wr(7'h00, 32'hFF);
        rd(7'h10, r); chk("R11 dropped", r, 32'h0);

        // R9: mask arithmetic
        wr(7'h18, 32'h0);
        rd(7'h18, r); chk("R9 mask cleared", r, 32'h0);
        wr(7'h1C, 32'hA5); rd(7'h18, r); chk("R9 unmask", r, 32'hA5);
        wr(7'h1C, 32'h00); rd(7'h18, r); chk("R9 unmask zero", r, 32'hA5);
        wr(7'h18, 32'hF0); rd(7'h18, r); chk("R9 mask clear", r, 32'hA0);
        wr(7'h18, 32'hFF); rd(7'h18, r); chk("R9 mask ones", r, 32'hA0);
        rd(7'h1C, r); chk("R9 unmask reads 0", r, 32'h0);
        rd(7'h14, r); chk("R9 clear reads 0", r, 32'h0);

        // R10: pending but masked gives no irq, unmask raises it
        wr(7'h24, 32'h0); wr(7'h18, 32'h0);
        @(negedge clk); pin_in = 8'h02; settle();
        rd(7'h10, r); chk("R10 pending", r, 32'h02);
        chk("R10 masked irq", {31'h0, irq}, 32'h0);
        wr(7'h1C, 32'h02);
        @(negedge clk);
        chk("R10 unmasked irq", {31'h0, irq}, 32'h1);

        finish_run();
    end
endmodule